// File: doc/BRIEF.md
# Multi-Mode Serial Channel

This block is one serial channel whose behaviour is chosen by an 8-bit mode byte. A 3-bit selector in that byte switches the channel off, selects clocked synchronous shifting of 8-bit words, or selects asynchronous framing with 7, 8 or 9 data bits. The other bits of the byte pick the shift-clock source for synchronous mode and, for asynchronous mode, the stop-bit count, parity and a receive sleep filter.

Software writes the mode byte through a simple write strobe and reads it back at any time. A word to send is presented on `tx_data` with a one-cycle `tx_start` strobe. Received words appear on `rx_data` with a one-cycle `rx_valid` pulse and two error flags. The bit rate comes from an external `baud_tick` pulse, one per oversampling slot, with 16 slots to a bit by default. The shift clock is split into an output, an output enable and an input so that it can be driven or followed.

Top module: `sio_multimode`

## Requirements
- R1: A write on `reg_wr` stores `reg_wdata` in the mode byte, and `reg_rdata` returns it from the next cycle. After reset the byte reads 0x00.
- R2: Selector bits [2:0] equal to 000, 010, 011 or 111 disable the channel. `txd` stays high, `sclk_oe` stays low, `tx_busy` stays low after `tx_start`, and no word is received.
- R3: Selectors 100, 101 and 110 give asynchronous frames of 7, 8 and 9 data bits. A frame is one low start bit and then the data bits LSB first. Each bit lasts OSR ticks, the line idles high, and `tx_busy` is high for the whole frame.
- R4: With bit 6 set, a parity bit follows the data bits. Bit 5 selects its sense: 0 gives odd parity over data plus parity, 1 gives even.
- R5: Bit 4 selects one high stop bit (0) or two (1) at the end of an asynchronous frame.
- R6: The asynchronous receiver samples each bit in its middle. It rejects a start bit that is no longer low at mid-bit. It delivers the data right-aligned with zeros above, together with a single-cycle `rx_valid` pulse.
- R7: `rx_par_err` is set with the delivered word when parity is enabled and the received parity bit does not match the selected sense.
- R8: `rx_frame_err` is set when any stop bit is sampled low. After a frame the receiver does not accept a new start bit until it has seen the line high.
- R9: With bit 7 set in asynchronous mode, a frame whose most significant data bit is 0 is dropped without `rx_valid`. A frame whose most significant data bit is 1 is delivered.
- R10: Selector 001 with bit 3 clear drives the shift clock (`sclk_oe` high). It makes 8 low pulses of OSR/2 ticks per half period and idles high. `txd` takes the next bit, LSB first, on each falling edge. `rxd` is sampled on each rising edge, and the 8 sampled bits are delivered LSB first with `rx_valid`.
- R11: Selector 001 with bit 3 set leaves `sclk_oe` low. Falling and rising edges of `sclk_in` shift the word in the same way as in R10, once `tx_start` has armed the transfer.
- R12: In synchronous mode, bits 4 to 6 have no effect on the transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Mode byte write strobe |
| reg_wdata | input | 8 | Mode byte write value |
| reg_rdata | output | 8 | Current mode byte |
| baud_tick | input | 1 | Oversampling tick, OSR per bit |
| tx_start | input | 1 | Start a transfer of `tx_data` |
| tx_data | input | 9 | Word to send, right-aligned |
| tx_busy | output | 1 | Transfer in progress |
| rx_data | output | 9 | Last received word, right-aligned |
| rx_valid | output | 1 | One-cycle pulse when a word is delivered |
| rx_par_err | output | 1 | Parity error of the delivered word |
| rx_frame_err | output | 1 | Stop-bit error of the delivered word |
| txd | output | 1 | Serial data out |
| rxd | input | 1 | Serial data in |
| sclk_out | output | 1 | Shift clock driven by the block |
| sclk_oe | output | 1 | Shift clock output enable |
| sclk_in | input | 1 | Shift clock from outside |

## Verification
The hardest case to reach from the ports is a low stop bit followed straight away by an idle line. It must raise the framing flag without letting the low level be taken as a new start bit, and with two stop bits only the first one is corrupted. The random frames corrupt stop bits, and separately parity bits, in about a quarter of the cases. The bench checks that each such frame gives exactly one delivery and that the next frame is received cleanly. The sleep filter is reached with directed 9-bit frames whose top bit is 0 and then 1, alongside random frames with sleep set at random.

// File: rtl/sio_pkg.sv
package sio_pkg;

  typedef enum logic [2:0] {
    CH_OFF,
    CH_SYNC,
    CH_A7,
    CH_A8,
    CH_A9
  } ch_mode_e;

  // mode byte layout, MSB first
  typedef struct packed {
    logic       sleep;
    logic       par_en;
    logic       par_even;
    logic       two_stop;
    logic       ext_clk;
    logic [2:0] sel;
  } mode_byte_t;

  function automatic ch_mode_e decode_sel(input logic [2:0] sel);
    case (sel)
      3'b001:  return CH_SYNC;
      3'b100:  return CH_A7;
      3'b101:  return CH_A8;
      3'b110:  return CH_A9;
      default: return CH_OFF;   // reserved codes behave as off
    endcase
  endfunction

  function automatic logic [3:0] data_len(input ch_mode_e m);
    case (m)
      CH_A7:   return 4'd7;
      CH_A9:   return 4'd9;
      default: return 4'd8;
    endcase
  endfunction

endpackage

// File: rtl/sio_async_tx.sv
module sio_async_tx #(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       tick,
  input  logic       start,
  input  logic [8:0] data,
  input  logic [3:0] nbits,
  input  logic       par_en,
  input  logic       par_even,
  input  logic       two_stop,
  output logic       txd,
  output logic       busy
);
  localparam int FW = 13;
  localparam int CW = $clog2(OSR);

  logic          busy_q, busy_d;
  logic [FW-1:0] sh_q, sh_d;
  logic [3:0]    left_q, left_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [FW-1:0] frame;
  logic [3:0]    len;
  logic [8:0]    dm;
  logic          pbit;

  always_comb begin
    dm    = data & ((9'h1 << nbits) - 9'h1);
    pbit  = par_even ? ^dm : ~^dm;
    frame = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < 9; i++) begin
      if (i < int'(nbits)) frame[i+1] = dm[i];
    end
    if (par_en) frame[int'(nbits)+1] = pbit;
    len = 4'd2 + nbits + {3'b0, par_en} + {3'b0, two_stop};
  end

  always_comb begin
    busy_d = busy_q;
    sh_d   = sh_q;
    left_d = left_q;
    cnt_d  = cnt_q;
    if (!en) begin
      busy_d = 1'b0;
      sh_d   = '1;
    end else if (!busy_q) begin
      if (start) begin
        busy_d = 1'b1;
        sh_d   = frame;
        left_d = len;
        cnt_d  = '0;
      end
    end else if (tick) begin
      if (cnt_q == CW'(OSR-1)) begin
        cnt_d  = '0;
        sh_d   = {1'b1, sh_q[FW-1:1]};
        left_d = left_q - 4'd1;
        if (left_q == 4'd1) busy_d = 1'b0;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sh_q   <= '1;
      left_q <= '0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      sh_q   <= sh_d;
      left_q <= left_d;
      cnt_q  <= cnt_d;
    end
  end

  assign txd  = sh_q[0];
  assign busy = busy_q;

  assert_start_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && start && !busy_q) |=> (busy_q && !txd));
  assert_idle_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> txd);

endmodule

// File: rtl/sio_async_rx.sv
module sio_async_rx #(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       tick,
  input  logic       rxd_s,
  input  logic [3:0] nbits,
  input  logic       par_en,
  input  logic       par_even,
  input  logic       two_stop,
  input  logic       sleep,
  output logic [8:0] data,
  output logic       perr,
  output logic       ferr,
  output logic       valid
);
  localparam int CW   = $clog2(OSR);
  localparam int HALF = OSR / 2;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} rx_st_e;

  rx_st_e        st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [3:0]    bit_q, bit_d;
  logic [8:0]    sh_q, sh_d;
  logic          acc_q, acc_d, pe_q, pe_d, fe_q, fe_d;
  logic          msb_q, msb_d, armed_q, armed_d, stop2_q, stop2_d;
  logic [8:0]    dat_q, dat_d;
  logic          operr_q, operr_d, oferr_q, oferr_d, val_q, val_d;
  logic          slot;

  assign slot = tick && (cnt_q == CW'(OSR-1));

  always_comb begin
    st_d = st_q; cnt_d = cnt_q; bit_d = bit_q; sh_d = sh_q;
    acc_d = acc_q; pe_d = pe_q; fe_d = fe_q; msb_d = msb_q;
    armed_d = armed_q; stop2_d = stop2_q;
    dat_d = dat_q; operr_d = operr_q; oferr_d = oferr_q; val_d = 1'b0;
    if (tick && st_q != S_IDLE && st_q != S_START && !slot) cnt_d = cnt_q + CW'(1);
    if (!en) begin
      st_d    = S_IDLE;
      armed_d = 1'b0;
    end else begin
      case (st_q)
        S_IDLE: begin
          if (rxd_s) armed_d = 1'b1;
          if (tick && armed_q && !rxd_s) begin
            st_d  = S_START;
            cnt_d = '0;
          end
        end
        S_START: if (tick) begin
          if (cnt_q == CW'(HALF-1)) begin
            cnt_d = '0;
            if (!rxd_s) begin
              st_d = S_DATA; bit_d = '0; acc_d = 1'b0; pe_d = 1'b0; fe_d = 1'b0;
            end else begin
              st_d = S_IDLE;
            end
          end else begin
            cnt_d = cnt_q + CW'(1);
          end
        end
        S_DATA: if (slot) begin
          cnt_d = '0;
          sh_d  = {rxd_s, sh_q[8:1]};
          acc_d = acc_q ^ rxd_s;
          bit_d = bit_q + 4'd1;
          if (bit_q == nbits - 4'd1) begin
            msb_d   = rxd_s;
            stop2_d = 1'b0;
            st_d    = par_en ? S_PAR : S_STOP;
          end
        end
        S_PAR: if (slot) begin
          cnt_d = '0;
          pe_d  = ((acc_q ^ rxd_s) != !par_even);
          st_d  = S_STOP;
        end
        S_STOP: if (slot) begin
          cnt_d = '0;
          fe_d  = fe_q | !rxd_s;
          if (two_stop && !stop2_q) begin
            stop2_d = 1'b1;
          end else begin
            st_d    = S_IDLE;
            armed_d = 1'b0;
            if (!(sleep && !msb_q)) begin
              val_d   = 1'b1;
              dat_d   = sh_q >> (4'd9 - nbits);
              operr_d = pe_q;
              oferr_d = fe_q | !rxd_s;
            end
          end
        end
        default: st_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; cnt_q <= '0; bit_q <= '0; sh_q <= '0;
      acc_q <= 1'b0; pe_q <= 1'b0; fe_q <= 1'b0; msb_q <= 1'b0;
      armed_q <= 1'b0; stop2_q <= 1'b0;
      dat_q <= '0; operr_q <= 1'b0; oferr_q <= 1'b0; val_q <= 1'b0;
    end else begin
      st_q <= st_d; cnt_q <= cnt_d; bit_q <= bit_d; sh_q <= sh_d;
      acc_q <= acc_d; pe_q <= pe_d; fe_q <= fe_d; msb_q <= msb_d;
      armed_q <= armed_d; stop2_q <= stop2_d;
      dat_q <= dat_d; operr_q <= operr_d; oferr_q <= oferr_d; val_q <= val_d;
    end
  end

  assign data  = dat_q;
  assign perr  = operr_q;
  assign ferr  = oferr_q;
  assign valid = val_q;

  assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    val_q |=> !val_q);
  assert_sleep_msb_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (val_q && sleep && $stable(nbits)) |-> dat_q[nbits - 4'd1]);
  assert_need_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_IDLE && !armed_q) |=> (st_q == S_IDLE));

endmodule

// File: rtl/sio_sync_shift.sv
module sio_sync_shift #(
  parameter int OSR       = 16,
  parameter int SYNC_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 ext_clk,
  input  logic                 tick,
  input  logic                 start,
  input  logic [SYNC_BITS-1:0] tx_word,
  input  logic                 rxd_s,
  input  logic                 sclk_s,
  output logic                 txd,
  output logic                 sclk_out,
  output logic                 sclk_oe,
  output logic                 busy,
  output logic [SYNC_BITS-1:0] rx_word,
  output logic                 done
);
  localparam int HALF = OSR / 2;
  localparam int HW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int BW   = $clog2(SYNC_BITS + 1);

  logic                 busy_q, busy_d, txd_q, txd_d, sclk_q, sclk_d;
  logic                 sprev_q, done_q, done_d;
  logic [SYNC_BITS-1:0] sh_q, sh_d;
  logic [HW-1:0]        h_q, h_d;
  logic [BW-1:0]        b_q, b_d;
  logic                 half_end, fall, rise;

  assign half_end = tick && (h_q == HW'(HALF-1));
  assign fall = busy_q && (ext_clk ? (sprev_q && !sclk_s) : (half_end && sclk_q));
  assign rise = busy_q && (ext_clk ? (!sprev_q && sclk_s) : (half_end && !sclk_q));

  always_comb begin
    busy_d = busy_q; txd_d = txd_q; sclk_d = sclk_q;
    sh_d = sh_q; h_d = h_q; b_d = b_q; done_d = 1'b0;
    if (!en) begin
      busy_d = 1'b0; txd_d = 1'b1; sclk_d = 1'b1; h_d = '0;
    end else if (!busy_q) begin
      sclk_d = 1'b1;
      if (start) begin
        busy_d = 1'b1; sh_d = tx_word; b_d = '0; h_d = '0;
      end
    end else begin
      if (!ext_clk && tick) h_d = half_end ? '0 : h_q + HW'(1);
      if (fall) begin
        txd_d = sh_q[0];
        if (!ext_clk) sclk_d = 1'b0;
      end
      if (rise) begin
        sh_d = {rxd_s, sh_q[SYNC_BITS-1:1]};
        if (!ext_clk) sclk_d = 1'b1;
        b_d = b_q + BW'(1);
        if (b_q == BW'(SYNC_BITS-1)) begin
          busy_d = 1'b0; done_d = 1'b1; txd_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; txd_q <= 1'b1; sclk_q <= 1'b1; sprev_q <= 1'b1;
      sh_q <= '0; h_q <= '0; b_q <= '0; done_q <= 1'b0;
    end else begin
      busy_q <= busy_d; txd_q <= txd_d; sclk_q <= sclk_d; sprev_q <= sclk_s;
      sh_q <= sh_d; h_q <= h_d; b_q <= b_d; done_q <= done_d;
    end
  end

  assign txd      = txd_q;
  assign sclk_out = sclk_q;
  assign sclk_oe  = en && !ext_clk;
  assign busy     = busy_q;
  assign rx_word  = sh_q;
  assign done     = done_q;

  assert_txd_on_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !ext_clk && $past(busy_q && !ext_clk) && !$stable(txd_q)) |-> $fell(sclk_q));

endmodule

// File: rtl/sio_multimode.sv
module sio_multimode #(
  parameter int OSR       = 16,
  parameter int SYNC_BITS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       baud_tick,
  input  logic       tx_start,
  input  logic [8:0] tx_data,
  output logic       tx_busy,
  output logic [8:0] rx_data,
  output logic       rx_valid,
  output logic       rx_par_err,
  output logic       rx_frame_err,
  output logic       txd,
  input  logic       rxd,
  output logic       sclk_out,
  output logic       sclk_oe,
  input  logic       sclk_in
);
  import sio_pkg::*;

  logic       rst_s1, rst_ns;
  mode_byte_t mode_q, mode_d;
  ch_mode_e   ch;
  logic       a_en, s_en;
  logic [3:0] nbits;
  logic [1:0] rxd_sync, sclk_sync;
  logic       a_txd, a_busy, s_txd, s_busy, s_done;
  logic [8:0] a_data;
  logic       a_perr, a_ferr, a_valid;
  logic [SYNC_BITS-1:0] s_word;
  logic [8:0] rd_q, rd_d;
  logic       rv_q, rv_d, rp_q, rp_d, rf_q, rf_d;

  // reset asserted asynchronously, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_ns <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_ns <= rst_s1;
    end
  end

  always_comb mode_d = reg_wr ? mode_byte_t'(reg_wdata) : mode_q;

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      mode_q    <= '0;
      rxd_sync  <= 2'b11;
      sclk_sync <= 2'b11;
    end else begin
      mode_q    <= mode_d;
      rxd_sync  <= {rxd_sync[0], rxd};
      sclk_sync <= {sclk_sync[0], sclk_in};
    end
  end

  assign ch    = decode_sel(mode_q.sel);
  assign a_en  = (ch == CH_A7) || (ch == CH_A8) || (ch == CH_A9);
  assign s_en  = (ch == CH_SYNC);
  assign nbits = data_len(ch);

  sio_async_tx #(.OSR(OSR)) u_atx (
    .clk(clk), .rst_n(rst_ns), .en(a_en), .tick(baud_tick), .start(tx_start),
    .data(tx_data), .nbits(nbits), .par_en(mode_q.par_en), .par_even(mode_q.par_even),
    .two_stop(mode_q.two_stop), .txd(a_txd), .busy(a_busy));

  sio_async_rx #(.OSR(OSR)) u_arx (
    .clk(clk), .rst_n(rst_ns), .en(a_en), .tick(baud_tick), .rxd_s(rxd_sync[1]),
    .nbits(nbits), .par_en(mode_q.par_en), .par_even(mode_q.par_even),
    .two_stop(mode_q.two_stop), .sleep(mode_q.sleep), .data(a_data),
    .perr(a_perr), .ferr(a_ferr), .valid(a_valid));

  sio_sync_shift #(.OSR(OSR), .SYNC_BITS(SYNC_BITS)) u_sync (
    .clk(clk), .rst_n(rst_ns), .en(s_en), .ext_clk(mode_q.ext_clk), .tick(baud_tick),
    .start(tx_start), .tx_word(tx_data[SYNC_BITS-1:0]), .rxd_s(rxd_sync[1]),
    .sclk_s(sclk_sync[1]), .txd(s_txd), .sclk_out(sclk_out), .sclk_oe(sclk_oe),
    .busy(s_busy), .rx_word(s_word), .done(s_done));

  always_comb begin
    rd_d = rd_q; rp_d = rp_q; rf_d = rf_q;
    rv_d = a_valid || s_done;
    if (s_done) begin
      rd_d = 9'(s_word); rp_d = 1'b0; rf_d = 1'b0;
    end else if (a_valid) begin
      rd_d = a_data; rp_d = a_perr; rf_d = a_ferr;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      rd_q <= '0; rv_q <= 1'b0; rp_q <= 1'b0; rf_q <= 1'b0;
    end else begin
      rd_q <= rd_d; rv_q <= rv_d; rp_q <= rp_d; rf_q <= rf_d;
    end
  end

  assign reg_rdata    = mode_q;
  assign tx_busy      = a_busy || s_busy;
  assign txd          = a_en ? a_txd : (s_en ? s_txd : 1'b1);
  assign rx_data      = rd_q;
  assign rx_valid     = rv_q;
  assign rx_par_err   = rp_q;
  assign rx_frame_err = rf_q;

  assert_readback_R1: assert property (@(posedge clk) disable iff (!rst_ns)
    $past(reg_wr) |-> (reg_rdata == $past(reg_wdata)));
  assert_off_quiet_R2: assert property (@(posedge clk) disable iff (!rst_ns)
    (!a_en && !s_en) |=> (!tx_busy && txd && !sclk_oe));
  assert_sclk_drive_R11: assert property (@(posedge clk) disable iff (!rst_ns)
    sclk_oe |-> (mode_q.sel == 3'b001 && !mode_q.ext_clk));

endmodule

// File: tb/sio_multimode_tb_top.sv
module sio_multimode_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 2;
  localparam int OSR        = 16;
  localparam int BITCLK     = OSR * TICK_DIV;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0, tx_start = 1'b0, rxd = 1'b1, sclk_in = 1'b1;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic [8:0] tx_data = '0, rx_data;
  logic baud_tick, tx_busy, rx_valid, rx_par_err, rx_frame_err, txd, sclk_out, sclk_oe;
  logic [1:0] tdiv;
  int n_run = 0, n_fail = 0, cap_n = 0, fall_n = 0;
  logic [8:0] cap_d;
  logic cap_p, cap_f, sclk_prev;
  bit done_flag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) tdiv <= '0;
    else        tdiv <= (tdiv == 2'(TICK_DIV-1)) ? '0 : tdiv + 2'd1;
  assign baud_tick = (tdiv == 2'(TICK_DIV-1));

  always @(negedge clk) begin
    if (rx_valid) begin
      cap_n = cap_n + 1; cap_d = rx_data; cap_p = rx_par_err; cap_f = rx_frame_err;
    end
    if (sclk_prev === 1'b1 && sclk_out === 1'b0) fall_n = fall_n + 1;
    sclk_prev = sclk_out;
  end

  sio_multimode #(.OSR(OSR), .SYNC_BITS(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .baud_tick(baud_tick), .tx_start(tx_start), .tx_data(tx_data), .tx_busy(tx_busy),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_par_err(rx_par_err),
    .rx_frame_err(rx_frame_err), .txd(txd), .rxd(rxd), .sclk_out(sclk_out),
    .sclk_oe(sclk_oe), .sclk_in(sclk_in));

  task automatic check(input string tag, input int act, input int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  function automatic int nb_of(input logic [7:0] m);
    return (m[2:0] == 3'b100) ? 7 : (m[2:0] == 3'b101) ? 8 : 9;
  endfunction

  // expected line bits of one asynchronous frame, first bit at index 0
  function automatic void make_frame(input logic [7:0] m, input logic [8:0] d,
                                     output logic [12:0] f, output int len, output int ppos);
    int nb = nb_of(m);
    int k = 1;
    logic p = 1'b0;
    f = '1; f[0] = 1'b0; ppos = -1;
    for (int i = 0; i < nb; i++) begin f[k] = d[i]; p = p ^ d[i]; k++; end
    if (m[6]) begin f[k] = m[5] ? p : ~p; ppos = k; k++; end
    f[k] = 1'b1; k++;
    if (m[4]) begin f[k] = 1'b1; k++; end
    len = k;
  endfunction

  task automatic write_mode(input logic [7:0] v);
    @(negedge clk); reg_wr = 1'b1; reg_wdata = v;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic pulse_start(input logic [8:0] d);
    @(negedge clk); tx_data = d; tx_start = 1'b1;
    @(negedge clk); tx_start = 1'b0;
  endtask

  // R3 R4 R5: sample the transmitted frame at bit centres
  task automatic async_tx(input logic [7:0] m, input logic [8:0] d);
    logic [12:0] f, got;
    int len, pp, n;
    make_frame(m, d, f, len, pp);
    pulse_start(d);
    n = 0;
    while (txd !== 1'b0 && n < 200) begin @(negedge clk); n++; end
    repeat (BITCLK/2 - 1) @(negedge clk);
    got = '1;
    for (int i = 0; i < len; i++) begin got[i] = txd; repeat (BITCLK) @(negedge clk); end
    check($sformatf("R3/R4/R5 tx frame mode=%0h", m), int'(got), int'(f));
    n = 0;
    while (tx_busy && n < 200) begin @(negedge clk); n++; end
    check("R3 busy clears and line idles high", int'({tx_busy, txd}), 1);
  endtask

  // R6 R7 R8 R9: drive one frame into rxd and compare the delivery
  task automatic async_rx(input logic [7:0] m, input logic [8:0] d, input bit bad_par,
                          input bit bad_stop);
    logic [12:0] f;
    int len, pp, c0, nb;
    bit exp_v;
    logic [8:0] dm;
    nb = nb_of(m);
    make_frame(m, d, f, len, pp);
    if (bad_par && pp >= 0) f[pp] = ~f[pp];
    if (bad_stop) f[nb + 1 + (m[6] ? 1 : 0)] = 1'b0;
    dm = d & 9'((1 << nb) - 1);
    exp_v = !(m[7] && !dm[nb-1]);
    c0 = cap_n;
    for (int i = 0; i < len; i++) begin
      @(negedge clk); rxd = f[i];
      repeat (BITCLK - 1) @(negedge clk);
    end
    @(negedge clk); rxd = 1'b1;
    repeat (2*BITCLK) @(negedge clk);
    check($sformatf("R6/R9 delivery count mode=%0h d=%0h", m, d), cap_n - c0, exp_v ? 1 : 0);
    if (exp_v && cap_n != c0) begin
      check("R6 rx data", int'(cap_d), int'(dm));
      check("R7 parity flag", int'(cap_p), (bad_par && m[6]) ? 1 : 0);
      check("R8 framing flag", int'(cap_f), bad_stop ? 1 : 0);
    end
  endtask

  // R10 R12: block drives the shift clock, bench acts as the far end
  task automatic sync_int(input logic [7:0] m, input logic [7:0] mb, input logic [7:0] sb);
    logic [7:0] got;
    int c0, f0, n;
    write_mode(m);
    c0 = cap_n; f0 = fall_n;
    pulse_start({1'b0, mb});
    for (int i = 0; i < 8; i++) begin
      n = 0;
      while (sclk_out !== 1'b0 && n < 400) begin @(negedge clk); n++; end
      got[i] = txd;
      rxd = sb[i];
      n = 0;
      while (sclk_out !== 1'b1 && n < 400) begin @(negedge clk); n++; end
    end
    repeat (4*BITCLK) @(negedge clk);
    rxd = 1'b1;
    check($sformatf("R10/R12 txd bits mode=%0h", m), int'(got), int'(mb));
    check("R10 eight clock pulses", fall_n - f0, 8);
    check("R10 clock driven and idle high", int'({sclk_oe, sclk_out}), 3);
    check("R10 one word received", cap_n - c0, 1);
    check("R10 received word", int'(cap_d), int'(sb));
  endtask

  // R11: bench supplies the shift clock
  task automatic sync_ext(input logic [7:0] mb, input logic [7:0] sb);
    logic [7:0] got;
    int c0;
    write_mode(8'h09);
    check("R11 clock not driven", int'(sclk_oe), 0);
    c0 = cap_n;
    pulse_start({1'b0, mb});
    repeat (4) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      sclk_in = 1'b0;
      repeat (8) @(negedge clk);
      got[i] = txd;
      rxd = sb[i];
      repeat (4) @(negedge clk);
      sclk_in = 1'b1;
      repeat (8) @(negedge clk);
    end
    repeat (8) @(negedge clk);
    rxd = 1'b1;
    check("R11 txd bits", int'(got), int'(mb));
    check("R11 one word received", cap_n - c0, 1);
    check("R11 received word", int'(cap_d), int'(sb));
    check("R11 clock still not driven", int'(sclk_oe), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] offm [4];
    int seed_v;
    offm[0] = 8'h00; offm[1] = 8'h02; offm[2] = 8'h03; offm[3] = 8'h07;
    seed_v = int'($urandom(32'h5EED_1234));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    check("R1 reset mode byte", int'(reg_rdata), 0);
    check("R2 reset outputs", int'({txd, tx_busy, sclk_oe, rx_valid}), 8);

    write_mode(8'hA5);
    check("R1 readback", int'(reg_rdata), 8'hA5);

    // R2: off and reserved codes
    foreach (offm[j]) begin
      int c0;
      write_mode(offm[j] | 8'h78);
      c0 = cap_n;
      pulse_start(9'h0AA);
      repeat (3) @(negedge clk);
      check($sformatf("R2 sel=%0h ignores start", offm[j]), int'({tx_busy, txd, sclk_oe}), 2);
      for (int i = 0; i < 10; i++) begin
        @(negedge clk); rxd = i[0];
        repeat (BITCLK - 1) @(negedge clk);
      end
      rxd = 1'b1;
      repeat (2*BITCLK) @(negedge clk);
      check("R2 nothing received", cap_n - c0, 0);
    end

    // directed asynchronous corners
    write_mode(8'h05); async_tx(8'h05, 9'h0A3);
    write_mode(8'h74); async_tx(8'h74, 9'h07F);
    write_mode(8'h56); async_tx(8'h56, 9'h1C4);
    write_mode(8'h05); async_rx(8'h05, 9'h03C, 0, 0);
    write_mode(8'h66); async_rx(8'h66, 9'h155, 1, 0);
    write_mode(8'h15); async_rx(8'h15, 9'h081, 0, 1);
    write_mode(8'h05); async_rx(8'h05, 9'h0F0, 0, 0);
    write_mode(8'h86); async_rx(8'h86, 9'h0FF, 0, 0);   // R9 msb 0 dropped
    async_rx(8'h86, 9'h100, 0, 0);                      // R9 msb 1 kept

    // constrained random asynchronous frames
    for (int it = 0; it < 24; it++) begin
      logic [7:0] m;
      logic [8:0] d;
      int s;
      s = int'($urandom_range(2, 0));
      m = {$urandom_range(1, 0) == 1, 4'($urandom_range(15, 0)), 3'(3'b100 + s)};
      d = 9'($urandom_range(511, 0));
      write_mode(m);
      async_tx(m, d);
      async_rx(m, d, $urandom_range(3, 0) == 0, $urandom_range(3, 0) == 0);
    end

    // synchronous transfers
    sync_int(8'h01, 8'hB4, 8'h5C);
    sync_int(8'h71, 8'h3B, 8'hE1);
    sync_ext(8'hC6, 8'h29);

    repeat (10) @(negedge clk);
    finish_run();
  end

endmodule